// File: doc/BRIEF.md
# Inter-Stage Dependency Token Queues

This block orders three decoupled task stages (load, compute and store) by passing tokens between them. It keeps four one-way token queues: load to compute, compute to load, compute to store, and store to compute. The hardware does not detect hazards. Software marks each task with flags that say which tokens it waits for before it starts and which tokens it hands on when it finishes. The block follows those flags and nothing else.

Each stage has two parts to its interface. The issue side carries a valid and a two-bit pop mask, and gets back a start grant. The done side carries a valid and a two-bit push mask, and gets back an acknowledge. The grant is raised in the same cycle as the request when every token named by the pop mask is there, and those tokens are taken on that clock edge. If a token is missing, the grant stays low, nothing is taken, and the stage keeps its task and asks again. A completion is acknowledged only when every queue named by the push mask has room, and the pushes land on that edge. The tokens carry no data, so each queue is a saturating counter, and its count is visible on an occupancy output.

Top module: `stage_token_sync`

## Requirements
- R1: After synchronous reset, all four occupancies read 0, and a task that needs any token is not granted.
- R2: For the load stage (stage index 0), mask bit 1 ("next") on issue pops compute-to-load (queue 1). Bit 1 on done pushes load-to-compute (queue 0).
- R3: For the compute stage (stage index 1), mask bit 0 ("prev") on issue pops queue 0 and bit 1 pops store-to-compute (queue 3). On done, bit 0 pushes queue 1 and bit 1 pushes compute-to-store (queue 2).
- R4: For the store stage (stage index 2), mask bit 0 on issue pops queue 2, and mask bit 0 on done pushes queue 3.
- R5: A start grant is given only when the issue is valid and every queue named by the pop mask is non-empty. If any named queue is empty, the grant is low and no occupancy changes.
- R6: A granted pop lowers the occupancy of its queue by one on the same clock edge, so the new count is visible in the next cycle.
- R7: A done acknowledge is given only when every queue named by the push mask holds fewer than DEPTH tokens. If it is withheld, no occupancy changes.
- R8: A push and a pop on the same queue in the same cycle leave its occupancy unchanged.
- R9: Load mask bit 0 and store mask bit 1 select no queue and are ignored, both on issue and on done.
- R10: A valid issue with an all-zero pop mask is granted at once, and a valid done with an all-zero push mask is acknowledged at once.
- R11: No occupancy exceeds DEPTH (default 8). A push into a full queue is not bypassed by a pop in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 3 | Task waiting to start, one bit per stage (0 load, 1 compute, 2 store) |
| issue_pops | input | 6 | Pop mask, two bits per stage: bit 2s is prev, bit 2s+1 is next |
| start_grant | output | 3 | Task may start; the tokens it needs are taken this cycle |
| done_valid | input | 3 | Task has finished, one bit per stage |
| done_pushes | input | 6 | Push mask, two bits per stage, same bit layout as issue_pops |
| done_ack | output | 3 | Completion accepted; the tokens are pushed this cycle |
| occupancy | output | 4*OCC_W | Token count per queue; queue q is at bits q*OCC_W and up |

## Verification
Grant and acknowledge are combinational from the inputs and the current counts, so they are due in the same cycle as the request. A pop or push changes the occupancy output one clock edge later. The bench drives inputs on the falling edge and samples all outputs a quarter period later, before the next rising edge. It compares them with a reference model whose counts are updated only after that comparison, so every expected value belongs to the state in force during the sampled cycle.

// File: rtl/stage_sync_pkg.sv
package stage_sync_pkg;

    localparam int NUM_STAGES = 3;
    localparam int NUM_QUEUES = 4;

    typedef enum logic [1:0] {
        STG_LOAD    = 2'd0,
        STG_COMPUTE = 2'd1,
        STG_STORE   = 2'd2
    } stage_e;

    typedef enum logic [1:0] {
        Q_LD2CMP = 2'd0,
        Q_CMP2LD = 2'd1,
        Q_CMP2ST = 2'd2,
        Q_ST2CMP = 2'd3
    } queue_e;

    // Two-bit direction mask: bit 0 is the upstream neighbour, bit 1 the downstream one.
    typedef struct packed {
        logic nxt;
        logic prv;
    } dir_mask_t;

    function automatic bit stage_has_prev(input int stg);
        return stg != int'(STG_LOAD);
    endfunction

    function automatic bit stage_has_next(input int stg);
        return stg != int'(STG_STORE);
    endfunction

    // Queue popped when waiting on the upstream neighbour.
    function automatic int prev_pop_q(input int stg);
        return (stg == int'(STG_STORE)) ? int'(Q_CMP2ST) : int'(Q_LD2CMP);
    endfunction

    // Queue pushed when releasing the upstream neighbour.
    function automatic int prev_push_q(input int stg);
        return (stg == int'(STG_STORE)) ? int'(Q_ST2CMP) : int'(Q_CMP2LD);
    endfunction

    // Queue popped when waiting on the downstream neighbour.
    function automatic int next_pop_q(input int stg);
        return (stg == int'(STG_LOAD)) ? int'(Q_CMP2LD) : int'(Q_ST2CMP);
    endfunction

    // Queue pushed when handing work to the downstream neighbour.
    function automatic int next_push_q(input int stg);
        return (stg == int'(STG_LOAD)) ? int'(Q_LD2CMP) : int'(Q_CMP2ST);
    endfunction

endpackage

// File: rtl/stage_sync_counter.sv
module stage_sync_counter #(
    parameter int DEPTH = 8,
    localparam int OCC_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    output logic [OCC_W-1:0] count,
    output logic             avail,
    output logic             space
);

    localparam logic [OCC_W-1:0] FULL_CNT = OCC_W'(DEPTH);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (push && !pop) begin
            count <= count + 1'b1;
        end else if (pop && !push) begin
            count <= count - 1'b1;
        end
    end

    assign avail = (count != '0);
    assign space = (count < FULL_CNT);

    // R11: count never passes the configured depth
    p_no_overflow_r11: assert property (@(posedge clk) disable iff (rst)
        count <= FULL_CNT);

    // R5: the stage side only pops a queue that holds a token
    p_no_underflow_r5: assert property (@(posedge clk) disable iff (rst)
        pop |-> count != '0);

    // R7: the stage side only pushes a queue that has room
    p_push_room_r7: assert property (@(posedge clk) disable iff (rst)
        push && !pop |-> count != FULL_CNT);

    // R6: a lone pop lowers the count by one at the next edge
    p_pop_dec_r6: assert property (@(posedge clk) disable iff (rst)
        pop && !push |=> count == $past(count) - 1'b1);

    // R8: a push paired with a pop holds the count
    p_pair_hold_r8: assert property (@(posedge clk) disable iff (rst)
        push && pop |=> $stable(count));

endmodule

// File: rtl/stage_sync_port.sv
module stage_sync_port
    import stage_sync_pkg::*;
#(
    parameter int STAGE = 0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  issue_valid,
    input  dir_mask_t             pop_mask,
    input  logic                  done_valid,
    input  dir_mask_t             push_mask,
    input  logic [NUM_QUEUES-1:0] q_avail,
    input  logic [NUM_QUEUES-1:0] q_space,
    output logic                  grant,
    output logic                  ack,
    output logic [NUM_QUEUES-1:0] pop_vec,
    output logic [NUM_QUEUES-1:0] push_vec
);

    localparam bit HAS_PREV = stage_has_prev(STAGE);
    localparam bit HAS_NEXT = stage_has_next(STAGE);
    localparam int PP_Q = prev_pop_q(STAGE);
    localparam int PU_Q = prev_push_q(STAGE);
    localparam int NP_Q = next_pop_q(STAGE);
    localparam int NU_Q = next_push_q(STAGE);

    logic [NUM_QUEUES-1:0] pop_need;
    logic [NUM_QUEUES-1:0] push_need;

    always_comb begin
        pop_need  = '0;
        push_need = '0;
        if (HAS_PREV && pop_mask.prv)  pop_need[PP_Q]  = 1'b1;
        if (HAS_NEXT && pop_mask.nxt)  pop_need[NP_Q]  = 1'b1;
        if (HAS_PREV && push_mask.prv) push_need[PU_Q] = 1'b1;
        if (HAS_NEXT && push_mask.nxt) push_need[NU_Q] = 1'b1;
    end

    assign grant    = issue_valid && ((q_avail | ~pop_need) == '1);
    assign ack      = done_valid && ((q_space | ~push_need) == '1);
    assign pop_vec  = grant ? pop_need  : '0;
    assign push_vec = ack   ? push_need : '0;

    // R5: no grant without a pending task
    p_grant_valid_r5: assert property (@(posedge clk) disable iff (rst)
        grant |-> issue_valid);

    // R7: no acknowledge without a finished task
    p_ack_valid_r7: assert property (@(posedge clk) disable iff (rst)
        ack |-> done_valid);

endmodule

// File: rtl/stage_token_sync.sv
module stage_token_sync
    import stage_sync_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int OCC_W = $clog2(DEPTH + 1)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_STAGES-1:0]       issue_valid,
    input  logic [2*NUM_STAGES-1:0]     issue_pops,
    output logic [NUM_STAGES-1:0]       start_grant,
    input  logic [NUM_STAGES-1:0]       done_valid,
    input  logic [2*NUM_STAGES-1:0]     done_pushes,
    output logic [NUM_STAGES-1:0]       done_ack,
    output logic [NUM_QUEUES*OCC_W-1:0] occupancy
);

    logic [NUM_QUEUES-1:0] q_avail;
    logic [NUM_QUEUES-1:0] q_space;
    logic [NUM_QUEUES-1:0] q_pop;
    logic [NUM_QUEUES-1:0] q_push;
    logic [NUM_QUEUES-1:0] st_pop  [NUM_STAGES];
    logic [NUM_QUEUES-1:0] st_push [NUM_STAGES];

    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
        stage_sync_port #(.STAGE(s)) u_port (
            .clk         (clk),
            .rst         (rst),
            .issue_valid (issue_valid[s]),
            .pop_mask    (dir_mask_t'(issue_pops[2*s +: 2])),
            .done_valid  (done_valid[s]),
            .push_mask   (dir_mask_t'(done_pushes[2*s +: 2])),
            .q_avail     (q_avail),
            .q_space     (q_space),
            .grant       (start_grant[s]),
            .ack         (done_ack[s]),
            .pop_vec     (st_pop[s]),
            .push_vec    (st_push[s])
        );
    end

    always_comb begin
        q_pop  = '0;
        q_push = '0;
        for (int s = 0; s < NUM_STAGES; s++) begin
            q_pop  = q_pop  | st_pop[s];
            q_push = q_push | st_push[s];
        end
    end

    for (genvar q = 0; q < NUM_QUEUES; q++) begin : g_queue
        stage_sync_counter #(.DEPTH(DEPTH)) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .push  (q_push[q]),
            .pop   (q_pop[q]),
            .count (occupancy[q*OCC_W +: OCC_W]),
            .avail (q_avail[q]),
            .space (q_space[q])
        );
    end

    // R3: a compute start that waits on loaded data only happens with a token present
    p_cmp_needs_data_r3: assert property (@(posedge clk) disable iff (rst)
        start_grant[1] && issue_pops[2] |-> occupancy[0 +: OCC_W] != '0);

    // R4: a store start that waits on compute output only happens with a token present
    p_st_needs_out_r4: assert property (@(posedge clk) disable iff (rst)
        start_grant[2] && issue_pops[4] |-> occupancy[2*OCC_W +: OCC_W] != '0);

    // R2: a load start that waits for a freed buffer only happens with a token present
    p_ld_needs_free_r2: assert property (@(posedge clk) disable iff (rst)
        start_grant[0] && issue_pops[1] |-> occupancy[OCC_W +: OCC_W] != '0);

endmodule

// File: tb/sim_stage_token_sync.sv
module sim_stage_token_sync;

    localparam int DEPTH = 8;
    localparam int OCC_W = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [2:0] issue_valid = '0;
    logic [5:0] issue_pops  = '0;
    logic [2:0] done_valid  = '0;
    logic [5:0] done_pushes = '0;
    logic [2:0] start_grant;
    logic [2:0] done_ack;
    logic [4*OCC_W-1:0] occupancy;

    int errors = 0;
    int checks = 0;
    int m_occ [4];
    bit finished = 0;

    always #10 clk = ~clk;

    stage_token_sync #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst),
        .issue_valid(issue_valid), .issue_pops(issue_pops), .start_grant(start_grant),
        .done_valid(done_valid), .done_pushes(done_pushes), .done_ack(done_ack),
        .occupancy(occupancy)
    );

    // Queue selected by stage s, direction bit b (0 prev, 1 next); -1 when none.
    function automatic int q_sel(input int s, input bit is_push, input int b);
        case (s)
            0: return (b == 1) ? (is_push ? 0 : 1) : -1;
            1: return (b == 0) ? (is_push ? 1 : 0) : (is_push ? 2 : 3);
            default: return (b == 0) ? (is_push ? 3 : 2) : -1;
        endcase
    endfunction

    task automatic chk(input int act, input int exp, input string tag, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic [2:0] iv, input logic [5:0] ip,
                        input logic [2:0] dv, input logic [5:0] dp, input string tag);
        int e_pop [4];
        int e_push [4];
        bit g, a;
        @(negedge clk);
        issue_valid = iv; issue_pops = ip; done_valid = dv; done_pushes = dp;
        for (int q = 0; q < 4; q++) begin e_pop[q] = 0; e_push[q] = 0; end
        #5;
        for (int q = 0; q < 4; q++)
            chk(int'(occupancy[q*OCC_W +: OCC_W]), m_occ[q], tag, $sformatf("occupancy q%0d", q));
        for (int s = 0; s < 3; s++) begin
            g = iv[s];
            a = dv[s];
            for (int b = 0; b < 2; b++) begin
                if (ip[2*s+b] && q_sel(s, 0, b) >= 0 && m_occ[q_sel(s, 0, b)] == 0) g = 0;
                if (dp[2*s+b] && q_sel(s, 1, b) >= 0 && m_occ[q_sel(s, 1, b)] == DEPTH) a = 0;
            end
            chk(int'(start_grant[s]), int'(g), tag, $sformatf("start_grant s%0d", s));
            chk(int'(done_ack[s]), int'(a), tag, $sformatf("done_ack s%0d", s));
            for (int b = 0; b < 2; b++) begin
                if (g && ip[2*s+b] && q_sel(s, 0, b) >= 0) e_pop[q_sel(s, 0, b)] = 1;
                if (a && dp[2*s+b] && q_sel(s, 1, b) >= 0) e_push[q_sel(s, 1, b)] = 1;
            end
        end
        for (int q = 0; q < 4; q++) m_occ[q] = m_occ[q] + e_push[q] - e_pop[q];
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int q = 0; q < 4; q++) m_occ[q] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: empty after reset, compute waiting on data is held
        step(3'b010, 6'b000100, 3'b000, 6'b0, "R1");
        // R9: load prev and store next select nothing
        step(3'b001, 6'b000001, 3'b100, 6'b100000, "R9");
        // R2: load pushes queue 0
        step(3'b000, 6'b0, 3'b001, 6'b000010, "R2");
        // R3 / R6: compute pops queue 0
        step(3'b010, 6'b000100, 3'b000, 6'b0, "R3");
        step(3'b000, 6'b0, 3'b000, 6'b0, "R6");
        // R3: compute pushes queues 1 and 2
        step(3'b000, 6'b0, 3'b010, 6'b001100, "R3");
        // R4: store pops queue 2, then pushes queue 3
        step(3'b100, 6'b010000, 3'b000, 6'b0, "R4");
        step(3'b000, 6'b0, 3'b100, 6'b010000, "R4");
        // R2: load pops queue 1
        step(3'b001, 6'b000010, 3'b000, 6'b0, "R2");
        // R5: compute needs queues 0 and 3, queue 0 empty
        step(3'b010, 6'b001100, 3'b000, 6'b0, "R5");
        // R10: empty masks pass at once
        step(3'b111, 6'b0, 3'b111, 6'b0, "R10");
        // R7 / R11: fill queue 0 and push past full
        for (int i = 0; i < DEPTH + 2; i++) step(3'b000, 6'b0, 3'b001, 6'b000010, "R7");
        // R11: push into full with simultaneous pop is refused
        step(3'b010, 6'b000100, 3'b001, 6'b000010, "R11");
        // R8: push and pop on a non-full queue hold the count
        step(3'b010, 6'b000100, 3'b001, 6'b000010, "R8");
        step(3'b000, 6'b0, 3'b000, 6'b0, "R8");
        // mixed traffic, phases biased towards filling then draining
        for (int i = 0; i < 4000; i++) begin
            logic [2:0] iv;
            logic [2:0] dv;
            logic [5:0] ip;
            logic [5:0] dp;
            iv = 3'($urandom);
            ip = 6'($urandom);
            dv = 3'($urandom);
            dp = 6'($urandom);
            if ((i / 500) % 2 == 0) iv = iv & 3'($urandom);
            else dv = dv & 3'($urandom);
            step(iv, ip, dv, dp, "R5");
        end
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule